// File: doc/BRIEF.md
# Indirect BAR Access Window

This block gives a driver a path into a BAR register region through configuration space alone. It holds four small registers: a BAR-select field, a BAR offset, an access length, and a 32-bit window word. Accesses to the window word are forwarded as single transactions on a simple master port toward the BAR register space.

A driver programs the select, offset and length fields, then touches the window word. A write to the window first stores the written value in the window word and then issues a BAR write at the programmed offset. The byte enables cover only the low `length` bytes. A read of the window first fetches from the BAR at the programmed offset. The low `length` bytes of the returned data are merged into the window word, and the updated word is then returned to the driver. Only one BAR is a legal target. An access that names another BAR, or a length other than 1, 2 or 4, is refused: the block raises an error flag, starts no BAR transaction and leaves the window word untouched.

The configuration port is a pulse-request / pulse-acknowledge interface. The requester pulses `cfg_req` for one cycle and waits for `cfg_ack` before it issues the next request.

Top module: `cfgwin_bridge`

## Requirements
- R1: After reset, all four registers read as zero, and `cfg_ack`, `cfg_err` and `bar_req` are low.
- R2: Register selector encoding: 0 = BAR select, 1 = offset, 2 = length, 3 = window word. A read or write of selectors 0 to 2 is acknowledged in the cycle after the request, with `cfg_err` low. These fields read back what was written, zero-extended and truncated to their widths. Such accesses never start a BAR transaction.
- R3: An accepted window write loads the written value into the window word. It then issues one BAR write at address = offset, with `bar_wdata` equal to the new window word.
- R4: A length of 1, 2 or 4 drives `bar_be` to 0001, 0011 or 1111 respectively, for both reads and writes.
- R5: An accepted window read issues one BAR read at address = offset. When the read completes, the byte lanes enabled by the length are replaced with the returned data, and the other lanes keep their earlier value. `cfg_rdata` on the acknowledge carries the updated word.
- R6: A BAR transaction holds `bar_req` and its address, enables and data steady until `bar_ready` is seen. The configuration acknowledge follows one cycle after that handshake, so no reply is given before the BAR side is ready.
- R7: When the BAR select is not 0, a window access is acknowledged in the next cycle with `cfg_err` high. No BAR transaction takes place, and the window word is unchanged.
- R8: When the length is not 1, 2 or 4, a window access is refused in the same way as in R7.
- R9: A configuration request that arrives while a BAR transaction is in flight is ignored and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_req | input | 1 | One-cycle configuration request pulse |
| cfg_we | input | 1 | 1 = write, 0 = read |
| cfg_sel | input | 2 | Register selector (see R2) |
| cfg_wdata | input | 32 | Write data |
| cfg_ack | output | 1 | One-cycle completion pulse |
| cfg_err | output | 1 | Refused access, valid with `cfg_ack` |
| cfg_rdata | output | 32 | Read data, valid with `cfg_ack` |
| bar_req | output | 1 | BAR transaction request |
| bar_we | output | 1 | BAR write when high |
| bar_addr | output | BAR_AW | BAR offset |
| bar_be | output | 4 | Byte enables |
| bar_wdata | output | 32 | BAR write data |
| bar_rdata | input | 32 | BAR read data, valid with `bar_ready` |
| bar_ready | input | 1 | BAR transaction completes |

## Verification
The bench builds the bridge with `BAR_AW` = 8 and leaves the other parameters at their defaults. With that width, a 256-word behavioural BAR model behind the master port covers every offset the bridge can drive. That model's ready latency is set per access, from zero to six cycles, so the tests reach both the immediate-handshake case and a long hold that leaves room to inject a request mid-flight. The 8-bit select and length fields make the refused encodings (select 1, length 0 or 3) directly reachable.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned LANES  = WORD_W / 8;

  typedef enum logic [1:0] {
    SEL_BARNUM = 2'd0,
    SEL_OFFSET = 2'd1,
    SEL_LENGTH = 2'd2,
    SEL_WINDOW = 2'd3
  } win_sel_e;

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_BUS  = 1'b1
  } phase_e;

  // Low-lane enables for a legal length, all-zero for an illegal one.
  function automatic logic [LANES-1:0] lanes_for_length(input logic [31:0] n);
    logic [LANES-1:0] en;
    en = '0;
    if (n == 32'd1 || n == 32'd2 || n == 32'd4) begin
      for (int i = 0; i < LANES; i++) en[i] = (32'(i) < n);
    end
    return en;
  endfunction

  // Replace enabled byte lanes of keep with those of fresh.
  function automatic logic [WORD_W-1:0] merge_lanes(input logic [WORD_W-1:0] keep,
                                                    input logic [WORD_W-1:0] fresh,
                                                    input logic [LANES-1:0]  en);
    logic [WORD_W-1:0] r;
    r = keep;
    for (int i = 0; i < LANES; i++) begin
      if (en[i]) r[8*i +: 8] = fresh[8*i +: 8];
    end
    return r;
  endfunction

endpackage

// File: rtl/cfgwin_regs.sv
module cfgwin_regs
  import cfgwin_pkg::*;
#(
  parameter int unsigned BAR_SEL_W = 8,
  parameter int unsigned BAR_AW    = 12,
  parameter int unsigned LEN_W     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 field_we,
  input  win_sel_e             wr_sel,
  input  logic [WORD_W-1:0]    wr_data,
  input  logic                 win_we,
  input  logic                 win_ld,
  input  logic [WORD_W-1:0]    ld_data,
  input  logic [LANES-1:0]     ld_en,
  input  win_sel_e             rd_sel,
  output logic [BAR_SEL_W-1:0] bar_q,
  output logic [BAR_AW-1:0]    off_q,
  output logic [LEN_W-1:0]     len_q,
  output logic [WORD_W-1:0]    win_q,
  output logic [WORD_W-1:0]    rd_word
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bar_q <= '0;
      off_q <= '0;
      len_q <= '0;
      win_q <= '0;
    end else begin
      if (field_we) begin
        case (wr_sel)
          SEL_BARNUM: bar_q <= wr_data[BAR_SEL_W-1:0];
          SEL_OFFSET: off_q <= wr_data[BAR_AW-1:0];
          SEL_LENGTH: len_q <= wr_data[LEN_W-1:0];
          default: ;
        endcase
      end
      if (win_we)      win_q <= wr_data;
      else if (win_ld) win_q <= merge_lanes(win_q, ld_data, ld_en);
    end
  end

  always_comb begin
    case (rd_sel)
      SEL_BARNUM: rd_word = WORD_W'(bar_q);
      SEL_OFFSET: rd_word = WORD_W'(off_q);
      SEL_LENGTH: rd_word = WORD_W'(len_q);
      default:    rd_word = win_q;
    endcase
  end

endmodule

// File: rtl/cfgwin_check.sv
module cfgwin_check
  import cfgwin_pkg::*;
#(
  parameter int unsigned BAR_SEL_W = 8,
  parameter int unsigned LEN_W     = 8,
  parameter int unsigned VALID_BAR = 0
) (
  input  logic [BAR_SEL_W-1:0] bar_q,
  input  logic [LEN_W-1:0]     len_q,
  output logic [LANES-1:0]     lane_en,
  output logic                 reject
);

  localparam logic [BAR_SEL_W-1:0] LEGAL_BAR = BAR_SEL_W'(VALID_BAR);

  assign lane_en = lanes_for_length(32'(len_q));
  assign reject  = (bar_q != LEGAL_BAR) || (lane_en == '0);

endmodule

// File: rtl/cfgwin_seq.sv
module cfgwin_seq
  import cfgwin_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     req,
  input  logic     we,
  input  win_sel_e sel,
  input  logic     reject,
  input  logic     bus_ready,
  output logic     taken,
  output logic     field_we,
  output logic     win_we,
  output logic     win_ld,
  output logic     bus_req,
  output logic     bus_we,
  output logic     ack,
  output logic     err,
  output win_sel_e sel_q
);

  phase_e phase;
  logic   is_win;

  assign taken    = req && (phase == PH_IDLE);
  assign is_win   = (sel == SEL_WINDOW);
  assign field_we = taken && we && !is_win;
  assign win_we   = taken && we && is_win && !reject;
  assign bus_req  = (phase == PH_BUS);
  assign win_ld   = bus_req && bus_ready && !bus_we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      bus_we <= 1'b0;
      ack    <= 1'b0;
      err    <= 1'b0;
      sel_q  <= SEL_BARNUM;
    end else begin
      ack <= 1'b0;
      err <= 1'b0;
      if (phase == PH_IDLE) begin
        if (taken) begin
          sel_q <= sel;
          if (!is_win) begin
            ack <= 1'b1;
          end else if (reject) begin
            ack <= 1'b1;
            err <= 1'b1;
          end else begin
            phase  <= PH_BUS;
            bus_we <= we;
          end
        end
      end else if (bus_ready) begin
        phase <= PH_IDLE;
        ack   <= 1'b1;
      end
    end
  end

  assert_reply_after_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_ready) |=> (ack && !err && !bus_req));

  assert_field_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && !is_win) |=> (ack && !err && !bus_req));

  assert_hold_kind_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ready) |=> (bus_req && $stable(bus_we)));

endmodule

// File: rtl/cfgwin_bridge.sv
module cfgwin_bridge
  import cfgwin_pkg::*;
#(
  parameter int unsigned BAR_SEL_W = 8,
  parameter int unsigned BAR_AW    = 12,
  parameter int unsigned LEN_W     = 8,
  parameter int unsigned VALID_BAR = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_req,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [31:0]       cfg_wdata,
  output logic              cfg_ack,
  output logic              cfg_err,
  output logic [31:0]       cfg_rdata,
  output logic              bar_req,
  output logic              bar_we,
  output logic [BAR_AW-1:0] bar_addr,
  output logic [3:0]        bar_be,
  output logic [31:0]       bar_wdata,
  input  logic [31:0]       bar_rdata,
  input  logic              bar_ready
);

  logic [BAR_SEL_W-1:0] bar_q;
  logic [BAR_AW-1:0]    off_q;
  logic [LEN_W-1:0]     len_q;
  logic [WORD_W-1:0]    win_q;
  logic [WORD_W-1:0]    rd_word;
  logic [LANES-1:0]     lane_en;
  logic                 reject;
  logic                 taken, field_we, win_we, win_ld;
  win_sel_e             sel_in, sel_q;

  assign sel_in = win_sel_e'(cfg_sel);

  cfgwin_seq u_seq (
    .clk(clk), .rst_n(rst_n), .req(cfg_req), .we(cfg_we), .sel(sel_in),
    .reject(reject), .bus_ready(bar_ready), .taken(taken), .field_we(field_we),
    .win_we(win_we), .win_ld(win_ld), .bus_req(bar_req), .bus_we(bar_we),
    .ack(cfg_ack), .err(cfg_err), .sel_q(sel_q)
  );

  cfgwin_check #(.BAR_SEL_W(BAR_SEL_W), .LEN_W(LEN_W), .VALID_BAR(VALID_BAR)) u_check (
    .bar_q(bar_q), .len_q(len_q), .lane_en(lane_en), .reject(reject)
  );

  cfgwin_regs #(.BAR_SEL_W(BAR_SEL_W), .BAR_AW(BAR_AW), .LEN_W(LEN_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .field_we(field_we), .wr_sel(sel_in), .wr_data(cfg_wdata),
    .win_we(win_we), .win_ld(win_ld), .ld_data(bar_rdata), .ld_en(lane_en),
    .rd_sel(sel_q), .bar_q(bar_q), .off_q(off_q), .len_q(len_q), .win_q(win_q),
    .rd_word(rd_word)
  );

  assign bar_addr  = off_q;
  assign bar_be    = lane_en;
  assign bar_wdata = win_q;
  assign cfg_rdata = cfg_ack ? rd_word : '0;

  assert_bus_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bar_req && !bar_ready) |=> (bar_req && $stable(bar_addr) && $stable(bar_be) && $stable(bar_wdata)));

  assert_be_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bar_req |-> (bar_be == 4'b0001 || bar_be == 4'b0011 || bar_be == 4'b1111));

  assert_reject_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && sel_in == SEL_WINDOW && reject) |=> (!bar_req && cfg_ack && cfg_err && $stable(win_q)));

  assert_write_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    win_we |=> (bar_req && bar_we && bar_wdata == $past(cfg_wdata)));

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!bar_req && !cfg_ack));

endmodule

// File: tb/test_cfgwin_bridge.sv
`timescale 1ns/1ps
module test_cfgwin_bridge;

  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_req = 1'b0, cfg_we = 1'b0;
  logic [1:0]    cfg_sel = 2'd0;
  logic [31:0]   cfg_wdata = '0;
  logic          cfg_ack, cfg_err;
  logic [31:0]   cfg_rdata;
  logic          bar_req, bar_we;
  logic [AW-1:0] bar_addr;
  logic [3:0]    bar_be;
  logic [31:0]   bar_wdata;
  logic [31:0]   bar_rdata = '0;
  logic          bar_ready = 1'b0;

  always #2 clk = ~clk;

  cfgwin_bridge #(.BAR_AW(AW)) i_cfgwin_bridge (
    .clk(clk), .rst_n(rst_n), .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_ack(cfg_ack), .cfg_err(cfg_err), .cfg_rdata(cfg_rdata),
    .bar_req(bar_req), .bar_we(bar_we), .bar_addr(bar_addr), .bar_be(bar_be),
    .bar_wdata(bar_wdata), .bar_rdata(bar_rdata), .bar_ready(bar_ready)
  );

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference state
  logic [31:0] mb = '0, mo = '0, ml = '0, md = '0;
  logic [31:0] mem [0:255];
  int lat = 0, wcnt = 0, bus_seen = 0;
  bit exp_on = 0, exp_we = 0;
  logic [AW-1:0] exp_addr = '0;
  logic [3:0] exp_be = '0;
  logic [31:0] exp_wd = '0;

  function automatic logic [3:0] be_of(input logic [31:0] len);
    if (len == 4) return 4'hF;
    if (len == 2) return 4'h3;
    if (len == 1) return 4'h1;
    return 4'h0;
  endfunction

  function automatic logic [31:0] blend(input logic [31:0] old, input logic [31:0] nw, input logic [3:0] be);
    logic [31:0] m;
    m = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
    return (old & ~m) | (nw & m);
  endfunction

  // BAR slave model with programmable latency
  always @(negedge clk) begin
    if (bar_req && !bar_ready) begin
      if (wcnt >= lat) begin
        bar_ready = 1'b1;
        bus_seen++;
        if (bar_we) mem[bar_addr] = blend(mem[bar_addr], bar_wdata, bar_be);
        else        bar_rdata = mem[bar_addr];
      end else begin
        wcnt++;
      end
    end else begin
      bar_ready = 1'b0;
      wcnt = 0;
    end
  end

  // Per-cycle comparison of the master port against the expectation
  always @(negedge clk) begin
    if (rst_n && bar_req) begin
      chk(exp_on, "R7/R8 unexpected BAR transaction", 32'(bar_req), 32'(exp_on));
      chk(bar_we == exp_we, "R3/R5 bar_we", 32'(bar_we), 32'(exp_we));
      chk(bar_addr == exp_addr, "R3/R5 bar_addr", 32'(bar_addr), 32'(exp_addr));
      chk(bar_be == exp_be, "R4 bar_be", 32'(bar_be), 32'(exp_be));
      if (exp_we) chk(bar_wdata == exp_wd, "R3 bar_wdata", bar_wdata, exp_wd);
    end
  end

  task automatic access(input logic [1:0] sel, input bit we, input logic [31:0] wd,
                        output logic [31:0] rd, output bit er, output int n);
    @(negedge clk);
    cfg_req = 1; cfg_we = we; cfg_sel = sel; cfg_wdata = wd;
    @(negedge clk);
    cfg_req = 0;
    n = 1;
    while (!cfg_ack && n < 60) begin
      @(negedge clk);
      n++;
    end
    rd = cfg_rdata;
    er = cfg_err;
  endtask

  task automatic setf(input logic [1:0] sel, input logic [31:0] v);
    logic [31:0] rd; bit er; int n;
    access(sel, 1'b1, v, rd, er, n);
    chk(n == 1, "R2 field write ack latency", 32'(n), 32'd1);
    chk(!er, "R2 field write err", 32'(er), 32'd0);
    case (sel)
      2'd0: mb = v & 32'hFF;
      2'd1: mo = v & 32'hFF;
      2'd2: ml = v & 32'hFF;
      default: ;
    endcase
  endtask

  task automatic getf(input logic [1:0] sel, input logic [31:0] want, input string tag);
    logic [31:0] rd; bit er; int n;
    access(sel, 1'b0, '0, rd, er, n);
    chk(n == 1 && !er, {tag, " field read ack"}, 32'(n), 32'd1);
    chk(rd == want, {tag, " field readback"}, rd, want);
  endtask

  task automatic window_op(input bit we, input logic [31:0] wd, input int l, input string tag);
    logic [31:0] rd, old; bit er, rej; int n, seen0; logic [3:0] be;
    be  = be_of(ml);
    rej = (mb != 0) || (be == 0);
    lat = l;
    exp_on = !rej; exp_we = we; exp_addr = mo[AW-1:0]; exp_be = be; exp_wd = wd;
    old = mem[mo[7:0]];
    seen0 = bus_seen;
    access(2'd3, we, wd, rd, er, n);
    exp_on = 0;
    if (rej) begin
      chk(er, {tag, " refused err"}, 32'(er), 32'd1);
      chk(n == 1, {tag, " refused ack latency"}, 32'(n), 32'd1);
      chk(bus_seen == seen0, {tag, " refused no transfer"}, 32'(bus_seen - seen0), 32'd0);
    end else begin
      if (we) begin
        md = wd;
        chk(mem[mo[7:0]] == blend(old, wd, be), {tag, " BAR contents"}, mem[mo[7:0]], blend(old, wd, be));
      end else begin
        md = blend(md, old, be);
      end
      chk(!er, {tag, " err"}, 32'(er), 32'd0);
      chk(n == l + 2, "R6 ack after ready", 32'(n), 32'(l + 2));
      chk(bus_seen == seen0 + 1, {tag, " one transfer"}, 32'(bus_seen - seen0), 32'd1);
    end
    chk(rd == md, {tag, " window word"}, rd, md);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = {8'(i), 8'(~i), 8'(i ^ 8'h5A), 8'hC3};
    mem[8'h30] = 32'h11223344;
    mem[8'h40] = 32'hCAFEBABE;
    repeat (3) @(negedge clk);
    chk(!cfg_ack && !cfg_err, "R1 reset ack/err", 32'(cfg_ack), 32'd0);
    chk(!bar_req, "R1 reset bar_req", 32'(bar_req), 32'd0);
    rst_n = 1;
    getf(2'd0, 32'd0, "R1");
    getf(2'd1, 32'd0, "R1");
    getf(2'd2, 32'd0, "R1");
    window_op(1'b0, '0, 0, "R1 R8 zero length");

    setf(2'd1, 32'h25); setf(2'd2, 32'd4); setf(2'd0, 32'd0);
    getf(2'd1, 32'h25, "R2"); getf(2'd2, 32'd4, "R2"); getf(2'd0, 32'd0, "R2");
    setf(2'd0, 32'h1FF); getf(2'd0, 32'hFF, "R2 truncation"); setf(2'd0, 32'd0);

    window_op(1'b1, 32'hA1B2C3D4, 0, "R3 write len4");
    setf(2'd1, 32'h30); setf(2'd2, 32'd1);
    window_op(1'b0, '0, 1, "R5 R4 read len1");
    setf(2'd2, 32'd2);
    window_op(1'b0, '0, 3, "R5 R4 read len2");
    setf(2'd2, 32'd4);
    window_op(1'b0, '0, 0, "R5 R4 read len4");

    // R9: request injected during a long BAR write is ignored
    begin
      logic [31:0] old; int n;
      setf(2'd1, 32'h40); setf(2'd2, 32'd2);
      lat = 6; exp_on = 1; exp_we = 1; exp_addr = 8'h40; exp_be = 4'h3; exp_wd = 32'h55667788;
      old = mem[8'h40];
      @(negedge clk); cfg_req = 1; cfg_we = 1; cfg_sel = 2'd3; cfg_wdata = 32'h55667788;
      @(negedge clk); cfg_req = 0; n = 1;
      repeat (2) begin @(negedge clk); n++; end
      cfg_req = 1; cfg_we = 1; cfg_sel = 2'd1; cfg_wdata = 32'h07;
      @(negedge clk); cfg_req = 0; n++;
      while (!cfg_ack && n < 60) begin @(negedge clk); n++; end
      exp_on = 0;
      md = 32'h55667788;
      chk(n == 8, "R6 long latency ack", 32'(n), 32'd8);
      chk(cfg_rdata == md, "R3 window word after write", cfg_rdata, md);
      chk(mem[8'h40] == blend(old, md, 4'h3), "R4 len2 write lanes", mem[8'h40], blend(old, md, 4'h3));
      getf(2'd1, 32'h40, "R9 ignored request");
    end

    setf(2'd0, 32'd1);
    window_op(1'b1, 32'hDEADBEEF, 0, "R7 bad BAR write");
    window_op(1'b0, '0, 0, "R7 bad BAR read");
    setf(2'd0, 32'd0); setf(2'd2, 32'd3);
    window_op(1'b1, 32'h0BADF00D, 0, "R8 length 3 write");
    window_op(1'b0, '0, 0, "R8 length 3 read");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog R6 actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule